// File: doc/BRIEF.md
# Three-Cycle-Issue RV32I Integer Core

A compact 32-bit integer core for simulation. It executes the base integer instruction set through four stages: fetch, decode, register read, and execute with write-back. The program lives in an internal ROM that is given as an array parameter. A 16-word data memory sits inside the core. Nothing outside the core drives instructions or data. The environment only supplies a clock and a reset, and it observes the core through two paths: a trace of retired program counters and a combinational debug read port into the register file.

Only one instruction is in flight at any time. A token starts on the first cycle after reset is released and then re-arms itself every third cycle. Each branch or jump is therefore resolved in time for the next fetch. The register file reads synchronously, so a read can be sampled in the same cycle as the previous instruction's write. For that reason the previous result is forwarded straight to the source operands. Whole-word loads and stores, all six conditional branches, JAL and JALR are supported.

Top module: `rv_slow_core`

## Requirements
- R1: After reset is released, `retire_o` pulses for one cycle every third cycle and never more often. A register-file write happens only in the cycle after a retire.
- R2: While reset is held, `retire_o` stays low and every register reads zero on the debug port.
- R3: A retired instruction that does not redirect control is followed by a retire at its PC plus 4. Every traced PC is word aligned.
- R4: The branch condition is selected by funct3: 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. A taken branch goes to PC plus the B-type immediate; a branch that is not taken falls through.
- R5: JAL writes PC+4 to rd and goes to PC plus the J-type immediate. JALR writes PC+4 to rd and goes to rs1 plus the I-type immediate, with bit 0 cleared.
- R6: When an instruction reads a register that the immediately preceding instruction wrote, it uses the new value.
- R7: Register x0 always reads zero. A write to x0 is dropped and is never forwarded.
- R8: Opcode bits [6:2] select the operation; bits [1:0] must be 11. The arithmetic path gives correct results for SUB (funct7 bit 5 set), SRAI, SLT, SLTU and LUI.
- R9: SW and LW use the byte address rs1+immediate. Bits [5:2] of that address select one of 16 data-memory words, and a stored word reads back unchanged.
- R10: A loop that sums 1 to 9, stores the sum, and loads it into x15 leaves 45 in x15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_o | output | 1 | High in the cycle an instruction executes |
| pc_o | output | 32 | PC of the executing instruction, meaningful when `retire_o` is high |
| dbg_idx | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Current content of register `dbg_idx` (combinational) |

## Verification
The bench runs one program and compares the retired-PC stream with a precomputed trace.

- A nine-pass counted loop whose backward branch depends on the instruction just before it tells working forwarding apart from stale register reads; a stale read changes the number of iterations.
- A chain of branches, some taken and some not, covering every funct3 condition tells each condition from its neighbours.
- A JALR with an odd sum checks that bit 0 is cleared.
- A write to x0 followed by a read of x0 tells proper suppression apart from forwarding through x0.
- Final register values read through the debug port confirm the arithmetic, link, and store-then-load results.

// File: rtl/rv_pkg.sv
package rv_pkg;

    localparam int XLEN       = 32;
    localparam int RF_AW      = 5;
    localparam int PROG_WORDS = 32;
    localparam int PROG_AW    = $clog2(PROG_WORDS);
    localparam logic [XLEN-1:0] NOP_WORD = 32'h0000_0013;

    localparam logic [4:0] OPC_LOAD   = 5'b00000;
    localparam logic [4:0] OPC_OPIMM  = 5'b00100;
    localparam logic [4:0] OPC_AUIPC  = 5'b00101;
    localparam logic [4:0] OPC_STORE  = 5'b01000;
    localparam logic [4:0] OPC_OP     = 5'b01100;
    localparam logic [4:0] OPC_LUI    = 5'b01101;
    localparam logic [4:0] OPC_BRANCH = 5'b11000;
    localparam logic [4:0] OPC_JALR   = 5'b11001;
    localparam logic [4:0] OPC_JAL    = 5'b11011;

    typedef logic [XLEN-1:0] prog_t [PROG_WORDS];

    typedef enum logic [3:0] {
        K_BAD, K_OP, K_OPIMM, K_LOAD, K_STORE,
        K_BRANCH, K_JAL, K_JALR, K_LUI, K_AUIPC
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [RF_AW-1:0]  rd;
        logic [RF_AW-1:0]  rs1;
        logic [RF_AW-1:0]  rs2;
        logic [2:0]        f3;
        logic              f7b5;
        logic [XLEN-1:0]   imm;
        logic              wr;
    } dec_t;

    function automatic logic [XLEN-1:0] alu_op(logic [2:0] f3, logic alt,
                                               logic [XLEN-1:0] a, logic [XLEN-1:0] b);
        logic [4:0] sh;
        sh = b[4:0];
        case (f3)
            3'b000:  return alt ? a - b : a + b;
            3'b001:  return a << sh;
            3'b010:  return {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
            3'b011:  return {{(XLEN-1){1'b0}}, a < b};
            3'b100:  return a ^ b;
            3'b101:  return alt ? XLEN'($signed(a) >>> sh) : a >> sh;
            3'b110:  return a | b;
            default: return a & b;
        endcase
    endfunction

    function automatic logic br_take(logic [2:0] f3, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
        case (f3)
            3'b000:  return a == b;
            3'b001:  return a != b;
            3'b100:  return $signed(a) < $signed(b);
            3'b101:  return $signed(a) >= $signed(b);
            3'b110:  return a < b;
            3'b111:  return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                          logic [2:0] f3, logic [4:0] rd, logic [4:0] op);
        return {f7, rs2, rs1, f3, rd, op, 2'b11};
    endfunction

    function automatic logic [31:0] enc_i(logic [31:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                          logic [4:0] rd, logic [4:0] op);
        return {imm[11:0], rs1, f3, rd, op, 2'b11};
    endfunction

    function automatic logic [31:0] enc_s(logic [31:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                          logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE, 2'b11};
    endfunction

    function automatic logic [31:0] enc_b(logic [31:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                          logic [2:0] f3);
        return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], OPC_BRANCH, 2'b11};
    endfunction

    function automatic logic [31:0] enc_u(logic [19:0] imm, logic [4:0] rd, logic [4:0] op);
        return {imm, rd, op, 2'b11};
    endfunction

    function automatic logic [31:0] enc_j(logic [31:0] imm, logic [4:0] rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL, 2'b11};
    endfunction

    // default image: sum 1..9, store, reload into x15, then spin
    function automatic prog_t sum_prog();
        prog_t p;
        for (int i = 0; i < PROG_WORDS; i++) p[i] = NOP_WORD;
        p[0] = enc_i(32'd0, 5'd0, 3'b000, 5'd10, OPC_OPIMM);
        p[1] = enc_i(32'd1, 5'd0, 3'b000, 5'd11, OPC_OPIMM);
        p[2] = enc_i(32'd10, 5'd0, 3'b000, 5'd12, OPC_OPIMM);
        p[3] = enc_r(7'd0, 5'd11, 5'd10, 3'b000, 5'd10, OPC_OP);
        p[4] = enc_i(32'd1, 5'd11, 3'b000, 5'd11, OPC_OPIMM);
        p[5] = enc_b(-32'sd8, 5'd12, 5'd11, 3'b100);
        p[6] = enc_s(32'd4, 5'd10, 5'd0, 3'b010);
        p[7] = enc_i(32'd4, 5'd0, 3'b010, 5'd15, OPC_LOAD);
        p[8] = enc_j(32'd0, 5'd0);
        return p;
    endfunction

endpackage

// File: rtl/rv_decode.sv
module rv_decode
    import rv_pkg::*;
(
    input  logic [XLEN-1:0] ins,
    output dec_t            d
);
    always_comb begin
        d      = '0;
        d.kind = K_BAD;
        d.rd   = ins[11:7];
        d.rs1  = ins[19:15];
        d.rs2  = ins[24:20];
        d.f3   = ins[14:12];
        d.f7b5 = ins[30];
        if (ins[1:0] == 2'b11) begin
            case (ins[6:2])
                OPC_OP:     d.kind = K_OP;
                OPC_OPIMM:  d.kind = K_OPIMM;
                OPC_LOAD:   d.kind = K_LOAD;
                OPC_STORE:  d.kind = K_STORE;
                OPC_BRANCH: d.kind = K_BRANCH;
                OPC_JAL:    d.kind = K_JAL;
                OPC_JALR:   d.kind = K_JALR;
                OPC_LUI:    d.kind = K_LUI;
                OPC_AUIPC:  d.kind = K_AUIPC;
                default:    d.kind = K_BAD;
            endcase
        end
        case (d.kind)
            K_STORE:       d.imm = {{20{ins[31]}}, ins[31:25], ins[11:7]};
            K_BRANCH:      d.imm = {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
            K_LUI, K_AUIPC: d.imm = {ins[31:12], 12'b0};
            K_JAL:         d.imm = {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
            default:       d.imm = {{20{ins[31]}}, ins[31:20]};
        endcase
        d.wr = (d.kind inside {K_OP, K_OPIMM, K_LOAD, K_JAL, K_JALR, K_LUI, K_AUIPC})
               && (d.rd != '0);
    end
endmodule

// File: rtl/rv_regfile.sv
module rv_regfile
    import rv_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              re_a,
    input  logic [RF_AW-1:0]  ra_a,
    output logic [XLEN-1:0]   rd_a,
    input  logic              re_b,
    input  logic [RF_AW-1:0]  ra_b,
    output logic [XLEN-1:0]   rd_b,
    input  logic              we,
    input  logic [RF_AW-1:0]  wa,
    input  logic [XLEN-1:0]   wd,
    input  logic [RF_AW-1:0]  dbg_a,
    output logic [XLEN-1:0]   dbg_d
);
    logic [XLEN-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
            rd_a <= '0;
            rd_b <= '0;
        end else begin
            if (we && wa != '0) mem[wa] <= wd;
            if (re_a) rd_a <= (ra_a == '0) ? '0 : mem[ra_a];
            if (re_b) rd_b <= (ra_b == '0) ? '0 : mem[ra_b];
        end
    end

    assign dbg_d = (dbg_a == '0) ? '0 : mem[dbg_a];
endmodule

// File: rtl/rv_dmem.sv
module rv_dmem
    import rv_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            re,
    input  logic            we,
    input  logic [AW-1:0]   idx,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);
    logic [XLEN-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = re ? mem[idx] : '0;
endmodule

// File: rtl/rv_slow_core.sv
module rv_slow_core
    import rv_pkg::*;
#(
    parameter prog_t PROG     = sum_prog(),
    parameter int    DM_WORDS = 16,
    localparam int   DM_AW    = $clog2(DM_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic             retire_o,
    output logic [XLEN-1:0]  pc_o,
    input  logic [RF_AW-1:0] dbg_idx,
    output logic [XLEN-1:0]  dbg_data
);
    // token: start pulse after reset falls, then re-armed by stage 3
    logic rst_q, start, v0, v1, v2, v3, vw;

    always_ff @(posedge clk) rst_q <= rst;
    assign start = rst_q & ~rst;
    assign v0    = start | v3;

    always_ff @(posedge clk) begin
        if (rst) {v1, v2, v3, vw} <= '0;
        else     {v1, v2, v3, vw} <= {v0, v1, v2, v3};
    end

    // fetch
    logic [XLEN-1:0] pc_r, pc_f, nxt_pc, ins_f;
    logic            in_rom;

    assign pc_f   = v3 ? nxt_pc : pc_r;
    assign in_rom = (pc_f[XLEN-1:PROG_AW+2] == '0);
    assign ins_f  = in_rom ? PROG[pc_f[PROG_AW+1:2]] : NOP_WORD;

    always_ff @(posedge clk) begin
        if (rst)     pc_r <= '0;
        else if (v3) pc_r <= nxt_pc;
    end

    logic [XLEN-1:0] pc1, ins1;
    always_ff @(posedge clk) begin
        if (rst) begin
            pc1  <= '0;
            ins1 <= NOP_WORD;
        end else if (v0) begin
            pc1  <= pc_f;
            ins1 <= ins_f;
        end
    end

    // decode, register read issued here (synchronous read)
    dec_t dec1;
    rv_decode u_dec (.ins(ins1), .d(dec1));

    logic [XLEN-1:0] rf_a, rf_b, wb_res;
    logic [RF_AW-1:0] wb_rd;
    logic            wb_we, rf_we;

    rv_regfile u_rf (
        .clk(clk), .rst(rst),
        .re_a(v1), .ra_a(dec1.rs1), .rd_a(rf_a),
        .re_b(v1), .ra_b(dec1.rs2), .rd_b(rf_b),
        .we(rf_we), .wa(wb_rd), .wd(wb_res),
        .dbg_a(dbg_idx), .dbg_d(dbg_data)
    );

    dec_t            d2;
    logic [XLEN-1:0] pc2;
    always_ff @(posedge clk) begin
        if (rst) begin
            d2  <= '0;
            pc2 <= '0;
        end else if (v1) begin
            d2  <= dec1;
            pc2 <= pc1;
        end
    end

    // operand select with forwarding of the previous result
    logic [XLEN-1:0] src_a, src_b;
    assign src_a = (wb_we && wb_rd == d2.rs1) ? wb_res : rf_a;
    assign src_b = (wb_we && wb_rd == d2.rs2) ? wb_res : rf_b;

    dec_t            d3;
    logic [XLEN-1:0] pc3, a3, b3;
    always_ff @(posedge clk) begin
        if (rst) begin
            d3  <= '0;
            pc3 <= '0;
            a3  <= '0;
            b3  <= '0;
        end else if (v2) begin
            d3  <= d2;
            pc3 <= pc2;
            a3  <= src_a;
            b3  <= src_b;
        end
    end

    // execute
    logic [XLEN-1:0] opnd_b, alu_y, addr, res3, dm_rdata;
    logic            alt, taken, dm_we, dm_re;

    assign opnd_b = (d3.kind == K_OP) ? b3 : d3.imm;
    assign alt    = d3.f7b5 & ((d3.kind == K_OP) | (d3.f3 == 3'b101));
    assign alu_y  = alu_op(d3.f3, alt, a3, opnd_b);
    assign addr   = a3 + d3.imm;
    assign taken  = (d3.kind == K_BRANCH) && br_take(d3.f3, a3, b3);
    assign dm_we  = v3 && (d3.kind == K_STORE);
    assign dm_re  = v3 && (d3.kind == K_LOAD);

    rv_dmem #(.WORDS(DM_WORDS)) u_dm (
        .clk(clk), .rst(rst), .re(dm_re), .we(dm_we),
        .idx(addr[DM_AW+1:2]), .wdata(b3), .rdata(dm_rdata)
    );

    always_comb begin
        case (d3.kind)
            K_LUI:          res3 = d3.imm;
            K_AUIPC:        res3 = pc3 + d3.imm;
            K_JAL, K_JALR:  res3 = pc3 + 32'd4;
            K_LOAD:         res3 = dm_rdata;
            default:        res3 = alu_y;
        endcase
        if (d3.kind == K_JAL)       nxt_pc = pc3 + d3.imm;
        else if (d3.kind == K_JALR) nxt_pc = addr & ~32'd1;
        else if (taken)             nxt_pc = pc3 + d3.imm;
        else                        nxt_pc = pc3 + 32'd4;
    end

    // write-back register, committed the cycle after execute
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_we  <= 1'b0;
            wb_rd  <= '0;
            wb_res <= '0;
        end else if (v3) begin
            wb_we  <= d3.wr;
            wb_rd  <= d3.rd;
            wb_res <= res3;
        end
    end
    assign rf_we = vw & wb_we;

    assign retire_o = v3;
    assign pc_o     = pc3;
endmodule

// File: rtl/rv_core_chk.sv
module rv_core_chk
    import rv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             retire,
    input logic [XLEN-1:0]  pc,
    input logic [RF_AW-1:0] dbg_idx,
    input logic [XLEN-1:0]  dbg_data,
    input logic             rf_we,
    input logic [RF_AW-1:0] rf_wa,
    input logic             dm_we
);
    AST_RETIRE_GAP1: assert property (@(posedge clk) disable iff (rst) retire |=> !retire); // R1
    AST_RETIRE_GAP2: assert property (@(posedge clk) disable iff (rst) retire |=> ##1 !retire); // R1
    AST_RETIRE_AGAIN: assert property (@(posedge clk) disable iff (rst) retire |=> ##2 retire); // R1
    AST_WB_AFTER_RETIRE: assert property (@(posedge clk) disable iff (rst) rf_we |-> $past(retire)); // R1
    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst) retire |-> pc[1:0] == 2'b00); // R3
    AST_X0_READS_ZERO: assert property (@(posedge clk) disable iff (rst) dbg_idx == '0 |-> dbg_data == '0); // R7
    AST_NO_WRITE_X0: assert property (@(posedge clk) disable iff (rst) rf_we |-> rf_wa != '0); // R7
    AST_STORE_ON_RETIRE: assert property (@(posedge clk) disable iff (rst) dm_we |-> retire); // R9
endmodule

bind rv_slow_core rv_core_chk u_chk (
    .clk(clk), .rst(rst), .retire(retire_o), .pc(pc_o),
    .dbg_idx(dbg_idx), .dbg_data(dbg_data),
    .rf_we(rf_we), .rf_wa(wb_rd), .dm_we(dm_we)
);

// File: tb/sim_rv_slow_core.sv
`timescale 1ns/1ps
module sim_rv_slow_core;
    import rv_pkg::*;

    function automatic prog_t build_prog();
        prog_t p;
        for (int i = 0; i < PROG_WORDS; i++) p[i] = NOP_WORD;
        p[0]  = enc_i(32'd0, 5'd0, 3'b000, 5'd10, OPC_OPIMM);
        p[1]  = enc_i(32'd1, 5'd0, 3'b000, 5'd11, OPC_OPIMM);
        p[2]  = enc_i(32'd10, 5'd0, 3'b000, 5'd12, OPC_OPIMM);
        p[3]  = enc_r(7'd0, 5'd11, 5'd10, 3'b000, 5'd10, OPC_OP);
        p[4]  = enc_i(32'd1, 5'd11, 3'b000, 5'd11, OPC_OPIMM);
        p[5]  = enc_b(-32'sd8, 5'd12, 5'd11, 3'b100);            // blt back
        p[6]  = enc_s(32'd4, 5'd10, 5'd0, 3'b010);                // sw x10,4(x0)
        p[7]  = enc_i(32'd4, 5'd0, 3'b010, 5'd15, OPC_LOAD);      // lw x15
        p[8]  = enc_i(32'd7, 5'd15, 3'b000, 5'd0, OPC_OPIMM);     // addi x0
        p[9]  = enc_r(7'd0, 5'd15, 5'd0, 3'b000, 5'd13, OPC_OP);  // add x13,x0,x15
        p[10] = enc_j(32'd12, 5'd1);                              // jal x1,+12
        p[11] = enc_i(32'd99, 5'd0, 3'b000, 5'd14, OPC_OPIMM);
        p[12] = enc_i(32'd98, 5'd0, 3'b000, 5'd14, OPC_OPIMM);
        p[13] = enc_r(7'h20, 5'd15, 5'd0, 3'b000, 5'd16, OPC_OP); // sub
        p[14] = enc_i(32'h402, 5'd16, 3'b101, 5'd17, OPC_OPIMM);  // srai 2
        p[15] = enc_r(7'd0, 5'd16, 5'd15, 3'b011, 5'd18, OPC_OP); // sltu
        p[16] = enc_r(7'd0, 5'd16, 5'd15, 3'b010, 5'd19, OPC_OP); // slt
        p[17] = enc_u(20'h12345, 5'd20, OPC_LUI);
        p[18] = enc_b(32'd8, 5'd15, 5'd16, 3'b101);               // bge  no
        p[19] = enc_b(32'd8, 5'd15, 5'd16, 3'b111);               // bgeu yes
        p[20] = enc_i(32'd97, 5'd0, 3'b000, 5'd14, OPC_OPIMM);
        p[21] = enc_b(32'd8, 5'd15, 5'd15, 3'b001);               // bne  no
        p[22] = enc_b(32'd8, 5'd15, 5'd15, 3'b000);               // beq  yes
        p[23] = enc_i(32'd96, 5'd0, 3'b000, 5'd14, OPC_OPIMM);
        p[24] = enc_b(32'd8, 5'd16, 5'd15, 3'b110);               // bltu yes
        p[25] = enc_i(32'd95, 5'd0, 3'b000, 5'd14, OPC_OPIMM);
        p[26] = enc_i(32'd65, 5'd1, 3'b000, 5'd5, OPC_JALR);      // jalr x5,65(x1)
        p[27] = enc_j(32'd0, 5'd0);                               // spin
        return p;
    endfunction

    localparam prog_t TB_PROG = build_prog();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        retire_o;
    logic [31:0] pc_o;
    logic [4:0]  dbg_idx = 5'd10;
    logic [31:0] dbg_data;

    always #4 clk = ~clk;

    rv_slow_core #(.PROG(TB_PROG)) u0 (
        .clk(clk), .rst(rst), .retire_o(retire_o), .pc_o(pc_o),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] exp_q [$];
    bit          mon_done = 1'b0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_pc(logic [31:0] pc);
        exp_q.push_back(pc);
    endtask

    // expected retire trace, derived from the program by hand
    task automatic drive_expect();
        push_pc(0); push_pc(4); push_pc(8);
        for (int k = 0; k < 9; k++) begin          // R6 loop of nine passes
            push_pc(12); push_pc(16); push_pc(20);
        end
        for (int a = 24; a <= 40; a += 4) push_pc(a);
        for (int a = 52; a <= 76; a += 4) push_pc(a);  // R5 jal skip
        push_pc(84); push_pc(88);                  // R4 bgeu taken
        push_pc(96);                               // R4 beq taken
        push_pc(104);                              // R4 bltu taken
        for (int k = 0; k < 4; k++) push_pc(108);  // R5 jalr, spin
    endtask

    // monitor: pops expected PCs, checks spacing
    initial begin
        int gap;
        bit first;
        first = 1'b1;
        gap   = 0;
        @(negedge clk);
        while (rst) @(negedge clk);
        while (exp_q.size() > 0) begin
            @(negedge clk);
            gap++;
            if (retire_o) begin
                if (!first) check("R1 retire spacing", 32'(gap), 32'd3);
                first = 1'b0;
                gap   = 0;
                check("R3 R4 R5 retired pc", pc_o, exp_q.pop_front());
            end
        end
        mon_done = 1'b1;
    end

    task automatic chk_reg(string req, logic [4:0] idx, logic [31:0] exp);
        dbg_idx = idx;
        #1;
        check(req, dbg_data, exp);
    endtask

    initial begin
        int cyc;
        drive_expect();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 no retire in reset", {31'd0, retire_o}, 32'd0);
        check("R2 reg zero in reset", dbg_data, 32'd0);
        rst = 1'b0;
        cyc = 0;
        while (!mon_done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (!mon_done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", exp_q.size(), 0);
        end
        chk_reg("R7 x0 zero", 5'd0, 32'd0);
        chk_reg("R10 sum in x10", 5'd10, 32'd45);
        chk_reg("R6 loop counter", 5'd11, 32'd10);
        chk_reg("R9 R10 loaded x15", 5'd15, 32'd45);
        chk_reg("R7 x0 not forwarded", 5'd13, 32'd45);
        chk_reg("R5 jal link", 5'd1, 32'd44);
        chk_reg("R5 jalr link", 5'd5, 32'd108);
        chk_reg("R4 skipped writes", 5'd14, 32'd0);
        chk_reg("R8 sub", 5'd16, 32'hFFFF_FFD3);
        chk_reg("R8 srai", 5'd17, 32'hFFFF_FFF4);
        chk_reg("R8 sltu", 5'd18, 32'd1);
        chk_reg("R8 slt", 5'd19, 32'd0);
        chk_reg("R8 lui", 5'd20, 32'h1234_5000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule